// File: doc/BRIEF.md
# Trapping Integer ALU with Compare

This block is a purely combinational 32-bit integer execution unit. A 6-bit operation code picks one of thirty-three operations: add and subtract in a checked form and a wrapping form, bitwise logic, complement, negate, absolute value, shifts and rotates, set-on-compare in signed and unsigned flavours, and conditional trap tests. The unit drives a 32-bit result, a signed-overflow exception flag and a trap flag in the same cycle its inputs settle.

The second operand is either the register value `src_b` or the 16-bit `imm_val`, selected by `use_imm`. The bitwise operations AND, OR, XOR and NOR widen the immediate with zeros. Every other operation widens it with copies of its bit 15. The operations that take one operand read only `src_a`. Each flag is raised only by the operations that own it. Exception handling, multiply, divide and register storage live outside the block.

Top module: `trap_int_alu`

## Requirements
- R1: ADD_CHK (code 0) and SUB_CHK (code 2) give the two's-complement sum `a+b` or difference `a-b`, wrapped to 32 bits. `ovf_exc` is 1 exactly when the true signed result does not fit in 32 bits, and the wrapped value is still driven on `result`.
- R2: ADD_WRAP (code 1), SUB_WRAP (code 3) and NEG_WRAP (code 10) give the wrapped sum, difference or negation, and never raise `ovf_exc`.
- R3: NEG_CHK (code 9) gives `0-a`, and ABS (code 11) gives `a` when `a` is non-negative and `0-a` otherwise. Each raises `ovf_exc` only when `a` is 0x80000000, and in that case `result` is 0x80000000.
- R4: When `use_imm` is 1 the second operand is `imm_val`. It is zero-extended for AND (4), OR (5), XOR (6) and NOR (7), and sign-extended for every other operation. When `use_imm` is 0 the second operand is `src_b`.
- R5: SHL (12), SHR (13) and SAR (14) shift `a` by the low 5 bits of the second operand, so the amount is taken modulo 32. SHL and SHR fill with zeros, and SAR fills with bit 31 of `a`.
- R6: ROTL (15) and ROTR (16) rotate `a` by the second operand modulo 32. ROTL moves bit 31 into bit 0, and ROTR moves bit 0 into bit 31.
- R7: The set operations write 1 when their relation holds and 0 otherwise, with both flags low. The codes are EQ 17, NE 18, LT 19, LE 20, GT 21 and GE 22 (signed), and LTU 23, LEU 24, GTU 25 and GEU 26 (unsigned).
- R8: The trap operations raise `trap_hit` when their relation holds, with `result` 0 and `ovf_exc` low. The codes are TEQ 27, TNE 28, TLT 29 (signed), TLTU 30, TGE 31 (signed) and TGEU 32.
- R9: Codes 33 to 63 give `result` 0 with both flags low. `ovf_exc` is only ever raised by codes 0, 2, 9 and 11, and `trap_hit` only by codes 27 to 32.
- R10: NOT (8) gives the bitwise complement of `a`, and NOR (7) gives the complement of `a|b`. Both raise no flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_code | input | 6 | Operation select |
| src_a | input | 32 | First operand |
| src_b | input | 32 | Register second operand |
| imm_val | input | 16 | Immediate second operand |
| use_imm | input | 1 | 1 selects the widened immediate as the second operand |
| result | output | 32 | Operation result |
| ovf_exc | output | 1 | Signed overflow exception |
| trap_hit | output | 1 | Trap condition met |

## Verification
The hardest cases to reach from the ports are the single operand values where a flag changes. The most negative input is the only value that makes negate or absolute value overflow. Operand pairs sitting exactly on the positive and negative limits are the only ones that make checked add and subtract overflow. The wrapping variants must stay quiet on those same values. The directed tasks drive these boundary values on purpose. They also set the immediate to 0xFFFF, where zero-extension and sign-extension give visibly different operands, and they use shift amounts above 31. Signed and unsigned compares and traps get operand pairs where the two readings of -1 against a small value disagree.

// File: rtl/tiu_pkg.sv
package tiu_pkg;
    localparam int OP_W = 6;

    typedef enum logic [OP_W-1:0] {
        OP_ADD_CHK  = 6'd0,
        OP_ADD_WRAP = 6'd1,
        OP_SUB_CHK  = 6'd2,
        OP_SUB_WRAP = 6'd3,
        OP_AND      = 6'd4,
        OP_OR       = 6'd5,
        OP_XOR      = 6'd6,
        OP_NOR      = 6'd7,
        OP_NOT      = 6'd8,
        OP_NEG_CHK  = 6'd9,
        OP_NEG_WRAP = 6'd10,
        OP_ABS      = 6'd11,
        OP_SHL      = 6'd12,
        OP_SHR      = 6'd13,
        OP_SAR      = 6'd14,
        OP_ROTL     = 6'd15,
        OP_ROTR     = 6'd16,
        OP_SET_EQ   = 6'd17,
        OP_SET_NE   = 6'd18,
        OP_SET_LT   = 6'd19,
        OP_SET_LE   = 6'd20,
        OP_SET_GT   = 6'd21,
        OP_SET_GE   = 6'd22,
        OP_SET_LTU  = 6'd23,
        OP_SET_LEU  = 6'd24,
        OP_SET_GTU  = 6'd25,
        OP_SET_GEU  = 6'd26,
        OP_TRP_EQ   = 6'd27,
        OP_TRP_NE   = 6'd28,
        OP_TRP_LT   = 6'd29,
        OP_TRP_LTU  = 6'd30,
        OP_TRP_GE   = 6'd31,
        OP_TRP_GEU  = 6'd32
    } op_e;

    localparam logic [OP_W-1:0] OP_LAST = 6'd32;

    typedef enum logic [2:0] {
        SH_LL  = 3'd0,
        SH_RL  = 3'd1,
        SH_RA  = 3'd2,
        SH_ROL = 3'd3,
        SH_ROR = 3'd4
    } shmode_e;
endpackage

// File: rtl/tiu_addsub.sv
module tiu_addsub #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    output logic [W-1:0] sum,
    output logic         ovf
);
    logic [W-1:0] b_x;

    always_comb begin
        b_x = sub ? ~b : b;
        sum = a + b_x + {{(W-1){1'b0}}, sub};
        ovf = (a[W-1] == b_x[W-1]) && (sum[W-1] != a[W-1]);
    end
endmodule

// File: rtl/tiu_shifter.sv
module tiu_shifter
    import tiu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0]         din,
    input  logic [$clog2(W)-1:0] amt,
    input  shmode_e              mode,
    output logic [W-1:0]         dout
);
    localparam int SH_W = $clog2(W);

    function automatic logic [W-1:0] step(input logic [W-1:0] cur,
                                          input shmode_e m,
                                          input int s);
        logic [W-1:0] r;
        case (m)
            SH_LL:   r = cur << s;
            SH_RL:   r = cur >> s;
            SH_RA:   r = W'($signed(cur) >>> s);
            SH_ROL:  r = (cur << s) | (cur >> (W - s));
            SH_ROR:  r = (cur >> s) | (cur << (W - s));
            default: r = cur;
        endcase
        return r;
    endfunction

    logic [SH_W:0][W-1:0] stg;

    assign stg[0] = din;

    for (genvar k = 0; k < SH_W; k++) begin : g_stage
        assign stg[k+1] = amt[k] ? step(stg[k], mode, 2**k) : stg[k];
    end

    assign dout = stg[SH_W];
endmodule

// File: rtl/tiu_compare.sv
module tiu_compare #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic         eq,
    output logic         lt_s,
    output logic         lt_u
);
    always_comb begin
        eq   = (a == b);
        lt_u = (a < b);
        lt_s = ($signed(a) < $signed(b));
    end
endmodule

// File: rtl/trap_int_alu.sv
module trap_int_alu
    import tiu_pkg::*;
#(
    parameter int W     = 32,
    parameter int IMM_W = 16
) (
    input  logic [OP_W-1:0]  op_code,
    input  logic [W-1:0]     src_a,
    input  logic [W-1:0]     src_b,
    input  logic [IMM_W-1:0] imm_val,
    input  logic             use_imm,
    output logic [W-1:0]     result,
    output logic             ovf_exc,
    output logic             trap_hit
);
    localparam int SH_W = $clog2(W);

    op_e          op;
    logic         zext;
    logic [W-1:0] imm_wide;
    logic [W-1:0] opnd_b;

    assign op = op_e'(op_code);

    always_comb begin
        zext     = (op == OP_AND) || (op == OP_OR) || (op == OP_XOR) || (op == OP_NOR);
        imm_wide = zext ? {{(W-IMM_W){1'b0}}, imm_val}
                        : {{(W-IMM_W){imm_val[IMM_W-1]}}, imm_val};
        opnd_b   = use_imm ? imm_wide : src_b;
    end

    // binary add / subtract
    logic         is_sub;
    logic [W-1:0] bin_sum;
    logic         bin_ovf;

    assign is_sub = (op == OP_SUB_CHK) || (op == OP_SUB_WRAP);

    tiu_addsub #(.W(W)) u_bin (
        .a   (src_a),
        .b   (opnd_b),
        .sub (is_sub),
        .sum (bin_sum),
        .ovf (bin_ovf)
    );

    // unary negate: 0 - a
    logic [W-1:0] neg_val;
    logic         neg_ovf;

    tiu_addsub #(.W(W)) u_neg (
        .a   ({W{1'b0}}),
        .b   (src_a),
        .sub (1'b1),
        .sum (neg_val),
        .ovf (neg_ovf)
    );

    // shifts and rotates
    shmode_e      sh_mode;
    logic [W-1:0] sh_out;

    always_comb begin
        unique case (op)
            OP_SHR:  sh_mode = SH_RL;
            OP_SAR:  sh_mode = SH_RA;
            OP_ROTL: sh_mode = SH_ROL;
            OP_ROTR: sh_mode = SH_ROR;
            default: sh_mode = SH_LL;
        endcase
    end

    tiu_shifter #(.W(W)) u_shift (
        .din  (src_a),
        .amt  (opnd_b[SH_W-1:0]),
        .mode (sh_mode),
        .dout (sh_out)
    );

    // relations
    logic c_eq, c_lt, c_ltu;

    tiu_compare #(.W(W)) u_cmp (
        .a    (src_a),
        .b    (opnd_b),
        .eq   (c_eq),
        .lt_s (c_lt),
        .lt_u (c_ltu)
    );

    function automatic logic [W-1:0] bool_w(input logic v);
        return {{(W-1){1'b0}}, v};
    endfunction

    always_comb begin
        result   = '0;
        ovf_exc  = 1'b0;
        trap_hit = 1'b0;
        case (op)
            OP_ADD_CHK, OP_SUB_CHK: begin
                result  = bin_sum;
                ovf_exc = bin_ovf;
            end
            OP_ADD_WRAP, OP_SUB_WRAP: result = bin_sum;
            OP_AND:      result = src_a & opnd_b;
            OP_OR:       result = src_a | opnd_b;
            OP_XOR:      result = src_a ^ opnd_b;
            OP_NOR:      result = ~(src_a | opnd_b);
            OP_NOT:      result = ~src_a;
            OP_NEG_CHK: begin
                result  = neg_val;
                ovf_exc = neg_ovf;
            end
            OP_NEG_WRAP: result = neg_val;
            OP_ABS: begin
                result  = src_a[W-1] ? neg_val : src_a;
                ovf_exc = src_a[W-1] & neg_ovf;
            end
            OP_SHL, OP_SHR, OP_SAR, OP_ROTL, OP_ROTR: result = sh_out;
            OP_SET_EQ:   result = bool_w(c_eq);
            OP_SET_NE:   result = bool_w(!c_eq);
            OP_SET_LT:   result = bool_w(c_lt);
            OP_SET_LE:   result = bool_w(c_lt || c_eq);
            OP_SET_GT:   result = bool_w(!(c_lt || c_eq));
            OP_SET_GE:   result = bool_w(!c_lt);
            OP_SET_LTU:  result = bool_w(c_ltu);
            OP_SET_LEU:  result = bool_w(c_ltu || c_eq);
            OP_SET_GTU:  result = bool_w(!(c_ltu || c_eq));
            OP_SET_GEU:  result = bool_w(!c_ltu);
            OP_TRP_EQ:   trap_hit = c_eq;
            OP_TRP_NE:   trap_hit = !c_eq;
            OP_TRP_LT:   trap_hit = c_lt;
            OP_TRP_LTU:  trap_hit = c_ltu;
            OP_TRP_GE:   trap_hit = !c_lt;
            OP_TRP_GEU:  trap_hit = !c_ltu;
            default: begin
                result   = '0;
                ovf_exc  = 1'b0;
                trap_hit = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/tiu_checker.sv
module tiu_checker
    import tiu_pkg::*;
#(
    parameter int W = 32
) (
    input logic [OP_W-1:0] op_code,
    input logic [W-1:0]    src_a,
    input logic [W-1:0]    src_b,
    input logic            use_imm,
    input logic [W-1:0]    result,
    input logic            ovf_exc,
    input logic            trap_hit
);
    localparam logic [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};

    always_comb begin
        // R1: checked add flags exactly the sign-rule overflow
        if (op_code == OP_ADD_CHK && !use_imm)
            p_add_ovf_r1: assert (ovf_exc == ((src_a[W-1] == src_b[W-1]) && (result[W-1] != src_a[W-1])))
                else $error("p_add_ovf_r1");
        // R2: wrapping forms stay quiet
        if (op_code == OP_ADD_WRAP || op_code == OP_SUB_WRAP || op_code == OP_NEG_WRAP)
            p_wrap_quiet_r2: assert (!ovf_exc) else $error("p_wrap_quiet_r2");
        // R3: negate / abs overflow only at the minimum value
        if (op_code == OP_NEG_CHK || op_code == OP_ABS)
            p_min_only_r3: assert (ovf_exc == (src_a == MINV)) else $error("p_min_only_r3");
        // R7: set results are boolean, no flags
        if (op_code >= OP_SET_EQ && op_code <= OP_SET_GEU)
            p_set_bool_r7: assert (result[W-1:1] == '0 && !ovf_exc && !trap_hit)
                else $error("p_set_bool_r7");
        // R8: traps leave result zero and overflow low
        if (op_code >= OP_TRP_EQ && op_code <= OP_TRP_GEU)
            p_trap_quiet_r8: assert (result == '0 && !ovf_exc) else $error("p_trap_quiet_r8");
        // R9: unused codes are inert
        if (op_code > OP_LAST)
            p_idle_r9: assert (result == '0 && !ovf_exc && !trap_hit) else $error("p_idle_r9");
        // R9: flags only from their owning codes
        if (trap_hit)
            p_trap_scope_r9: assert (op_code >= OP_TRP_EQ && op_code <= OP_TRP_GEU)
                else $error("p_trap_scope_r9");
        if (ovf_exc)
            p_ovf_scope_r9: assert (op_code == OP_ADD_CHK || op_code == OP_SUB_CHK ||
                                    op_code == OP_NEG_CHK || op_code == OP_ABS)
                else $error("p_ovf_scope_r9");
    end
endmodule

bind trap_int_alu tiu_checker #(.W(W)) u_tiu_checker (
    .op_code  (op_code),
    .src_a    (src_a),
    .src_b    (src_b),
    .use_imm  (use_imm),
    .result   (result),
    .ovf_exc  (ovf_exc),
    .trap_hit (trap_hit)
);

// File: tb/trap_int_alu_bench.sv
module trap_int_alu_bench;
    logic        clk = 1'b0;
    logic [5:0]  op_code = 6'd63;
    logic [31:0] src_a = '0;
    logic [31:0] src_b = '0;
    logic [15:0] imm_val = '0;
    logic        use_imm = 1'b0;
    logic [31:0] result;
    logic        ovf_exc;
    logic        trap_hit;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    trap_int_alu u_trap_int_alu (
        .op_code  (op_code),
        .src_a    (src_a),
        .src_b    (src_b),
        .imm_val  (imm_val),
        .use_imm  (use_imm),
        .result   (result),
        .ovf_exc  (ovf_exc),
        .trap_hit (trap_hit)
    );

    task automatic run(input string tag, input logic [5:0] op,
                       input logic [31:0] a, input logic [31:0] b,
                       input logic [15:0] imm, input logic ui,
                       input logic [31:0] e_res, input logic e_ovf, input logic e_trp);
        @(negedge clk);
        op_code = op; src_a = a; src_b = b; imm_val = imm; use_imm = ui;
        #1;
        n_chk++;
        if (result !== e_res || ovf_exc !== e_ovf || trap_hit !== e_trp) begin
            n_bad++;
            $display("FAIL %s: got res=%h ovf=%b trap=%b, expected res=%h ovf=%b trap=%b",
                     tag, result, ovf_exc, trap_hit, e_res, e_ovf, e_trp);
        end
    endtask

    task automatic t_idle_start;
        #1;
        n_chk++;
        if (result !== 32'h0 || ovf_exc !== 1'b0 || trap_hit !== 1'b0) begin
            n_bad++;
            $display("FAIL R9 start: got res=%h ovf=%b trap=%b, expected 0 0 0",
                     result, ovf_exc, trap_hit);
        end
    endtask

    task automatic t_checked_arith;
        run("R1 add pos limit", 6'd0, 32'h7FFFFFFF, 32'h1, 16'h0, 0, 32'h80000000, 1, 0);
        run("R1 add plain",     6'd0, 32'h5, 32'hFFFFFFFD, 16'h0, 0, 32'h2, 0, 0);
        run("R1 sub neg limit", 6'd2, 32'h80000000, 32'h1, 16'h0, 0, 32'h7FFFFFFF, 1, 0);
        run("R1 sub plain",     6'd2, 32'h3, 32'h5, 16'h0, 0, 32'hFFFFFFFE, 0, 0);
        run("R1 sub zero-min",  6'd2, 32'h0, 32'h80000000, 16'h0, 0, 32'h80000000, 1, 0);
        run("R4 add imm sext",  6'd0, 32'd10, 32'h0, 16'hFFFF, 1, 32'd9, 0, 0);
    endtask

    task automatic t_wrap_arith;
        run("R2 addu limit", 6'd1, 32'h7FFFFFFF, 32'h1, 16'h0, 0, 32'h80000000, 0, 0);
        run("R2 subu limit", 6'd3, 32'h80000000, 32'h1, 16'h0, 0, 32'h7FFFFFFF, 0, 0);
        run("R2 negu min",   6'd10, 32'h80000000, 32'h0, 16'h0, 0, 32'h80000000, 0, 0);
    endtask

    task automatic t_unary;
        run("R3 neg 5",     6'd9, 32'd5, 32'h0, 16'h0, 0, 32'hFFFFFFFB, 0, 0);
        run("R3 neg min",   6'd9, 32'h80000000, 32'h0, 16'h0, 0, 32'h80000000, 1, 0);
        run("R3 abs -7",    6'd11, 32'hFFFFFFF9, 32'h0, 16'h0, 0, 32'd7, 0, 0);
        run("R3 abs min",   6'd11, 32'h80000000, 32'h0, 16'h0, 0, 32'h80000000, 1, 0);
        run("R3 abs 9",     6'd11, 32'd9, 32'h0, 16'h0, 0, 32'd9, 0, 0);
        run("R10 not",      6'd8, 32'h0F0F0F0F, 32'hFFFFFFFF, 16'h0, 0, 32'hF0F0F0F0, 0, 0);
    endtask

    task automatic t_logic;
        run("R4 and imm zext", 6'd4, 32'hFFFFFFFF, 32'h0, 16'h8001, 1, 32'h00008001, 0, 0);
        run("R4 or imm zext",  6'd5, 32'h12340000, 32'h0, 16'hFFFF, 1, 32'h1234FFFF, 0, 0);
        run("R4 xor reg",      6'd6, 32'hFF00FF00, 32'h0FF00FF0, 16'hFFFF, 0, 32'hF0F0F0F0, 0, 0);
        run("R10 nor reg",     6'd7, 32'h0, 32'hF0F0F0F0, 16'h0, 0, 32'h0F0F0F0F, 0, 0);
        run("R10 nor imm",     6'd7, 32'h0, 32'h0, 16'hFFFF, 1, 32'hFFFF0000, 0, 0);
    endtask

    task automatic t_shift;
        run("R5 shl by 33",    6'd12, 32'h1, 32'd33, 16'h0, 0, 32'h2, 0, 0);
        run("R5 shr by 31",    6'd13, 32'h80000000, 32'd31, 16'h0, 0, 32'h1, 0, 0);
        run("R5 sar by 4",     6'd14, 32'h80000000, 32'd4, 16'h0, 0, 32'hF8000000, 0, 0);
        run("R5 shr by 4",     6'd13, 32'h80000000, 32'd4, 16'h0, 0, 32'h08000000, 0, 0);
        run("R5 shl imm -1",   6'd12, 32'h1, 32'h0, 16'hFFFF, 1, 32'h80000000, 0, 0);
        run("R5 sar positive", 6'd14, 32'h40000000, 32'd30, 16'h0, 0, 32'h1, 0, 0);
    endtask

    task automatic t_rotate;
        run("R6 rotl 1",  6'd15, 32'h80000001, 32'd1, 16'h0, 0, 32'h00000003, 0, 0);
        run("R6 rotr 1",  6'd16, 32'h80000001, 32'd1, 16'h0, 0, 32'hC0000000, 0, 0);
        run("R6 rotl 36", 6'd15, 32'h12345678, 32'd36, 16'h0, 0, 32'h23456781, 0, 0);
        run("R6 rotr 32", 6'd16, 32'h12345678, 32'd32, 16'h0, 0, 32'h12345678, 0, 0);
        run("R6 rotr 8",  6'd16, 32'h12345678, 32'd8, 16'h0, 0, 32'h78123456, 0, 0);
    endtask

    task automatic t_set;
        run("R7 lt signed",    6'd19, 32'hFFFFFFFF, 32'h1, 16'h0, 0, 32'h1, 0, 0);
        run("R7 ltu",          6'd23, 32'hFFFFFFFF, 32'h1, 16'h0, 0, 32'h0, 0, 0);
        run("R7 gt signed",    6'd21, 32'h1, 32'hFFFFFFFF, 16'h0, 0, 32'h1, 0, 0);
        run("R7 gtu",          6'd25, 32'h1, 32'hFFFFFFFF, 16'h0, 0, 32'h0, 0, 0);
        run("R7 le equal",     6'd20, 32'd4, 32'd4, 16'h0, 0, 32'h1, 0, 0);
        run("R7 ge below",     6'd22, 32'd2, 32'd3, 16'h0, 0, 32'h0, 0, 0);
        run("R7 leu equal",    6'd24, 32'hFFFFFFFF, 32'hFFFFFFFF, 16'h0, 0, 32'h1, 0, 0);
        run("R7 geu below",    6'd26, 32'h0, 32'h1, 16'h0, 0, 32'h0, 0, 0);
        run("R7 eq",           6'd17, 32'd7, 32'd7, 16'h0, 0, 32'h1, 0, 0);
        run("R7 ne",           6'd18, 32'd7, 32'd7, 16'h0, 0, 32'h0, 0, 0);
        run("R7 lt imm sext",  6'd19, 32'h0, 32'h0, 16'hFFFF, 1, 32'h0, 0, 0);
    endtask

    task automatic t_trap;
        run("R8 teq hit",   6'd27, 32'd9, 32'd9, 16'h0, 0, 32'h0, 0, 1);
        run("R8 tne miss",  6'd28, 32'd9, 32'd9, 16'h0, 0, 32'h0, 0, 0);
        run("R8 tlt hit",   6'd29, 32'hFFFFFFFF, 32'h0, 16'h0, 0, 32'h0, 0, 1);
        run("R8 tltu miss", 6'd30, 32'hFFFFFFFF, 32'h0, 16'h0, 0, 32'h0, 0, 0);
        run("R8 tge hit",   6'd31, 32'h0, 32'hFFFFFFFF, 16'h0, 0, 32'h0, 0, 1);
        run("R8 tgeu miss", 6'd32, 32'h0, 32'hFFFFFFFF, 16'h0, 0, 32'h0, 0, 0);
        run("R8 tgeu eq",   6'd32, 32'd5, 32'd5, 16'h0, 0, 32'h0, 0, 1);
    endtask

    task automatic t_unused;
        run("R9 code 40", 6'd40, 32'h80000000, 32'h80000000, 16'h0, 0, 32'h0, 0, 0);
        run("R9 code 63", 6'd63, 32'hFFFFFFFF, 32'h1, 16'hFFFF, 1, 32'h0, 0, 0);
        run("R9 code 33", 6'd33, 32'd5, 32'd5, 16'h0, 0, 32'h0, 0, 0);
    endtask

    initial begin
        t_idle_start();
        t_checked_arith();
        t_wrap_arith();
        t_unary();
        t_logic();
        t_shift();
        t_rotate();
        t_set();
        t_trap();
        t_unused();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #400000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule